// File: doc/BRIEF.md
# Inclusive Second-Level Cache Controller

This block is a blocking, write-back, write-allocate second-level cache. It sits between a first-level data cache and a main memory that answers requests over a separate response channel. The first-level cache offers one request at a time: a load or a store of a whole line at a byte address. It sees at once, on the same port, whether the request was taken. Load results come back in order on a response port as a line with a valid flag, and the consumer takes them when it is ready.

Storage is direct-mapped: 64 sets of 128-bit lines (four 32-bit words), each set with its own valid and dirty bit. Address bits [3:0] are the byte offset and are ignored. Bits [9:4] select the set and bits [31:10] form the tag. The controller keeps one miss outstanding and stops looking up new requests until that miss is filled. Before a dirty line is replaced, its data goes back to memory. The cache keeps the first-level cache a subset of itself: whenever a valid line leaves, an invalidate carrying that line's address is sent up, and the controller does nothing further until the invalidate has been taken.

Top module: `l2_inclusive_cache`

## Requirements
- R1: After reset every line is invalid. `req_accepted` is high, and `resp_valid`, `mem_req_valid`, `inv_valid` and `mem_resp_ready` are low.
- R2: Up to two requests wait in an input queue, and `req_accepted` is low exactly while two are held.
- R3: No request is looked up while a miss is outstanding, a memory request is unsent or an invalidate is untaken. At most one line read is in flight at any time.
- R4: On a tag hit, a load queues the stored line as a response. A store replaces the line, marks it dirty and makes no memory request. Either way the request is retired.
- R5: On a miss where the set holds a valid dirty line, the controller clears that line and issues a write (`mem_req_write`=1) of its data to the victim's line address. The request stays queued and is looked up again.
- R6: On a miss where the set is clean or invalid, the controller records the request and issues a read (`mem_req_write`=0) at the request's line address (offset bits zero). The request is then retired from the input queue.
- R7: A fill happens when memory answers while `mem_resp_ready` is high. `mem_resp_ready` is high only while a miss is outstanding and, for a load miss, the response queue has room. A load fill stores the memory line as clean and also queues it as a response. A store fill stores the request's data as dirty.
- R8: Each eviction of a valid line, dirty or clean, raises `inv_valid` with the victim's line address (offset bits zero). `inv_valid` and `inv_addr` hold until `inv_ready`.
- R9: A memory request holds its valid, kind, address and data stable until `mem_req_ready`.
- R10: Responses leave in the order they were produced. The front one stays on `resp_data` with `resp_valid` high until `resp_take`. The response queue holds two lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is offered |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 128 | Line data for a store |
| req_accepted | output | 1 | Offered request is taken at this edge |
| resp_take | input | 1 | Consumer removes the front response |
| resp_valid | output | 1 | A load response is available |
| resp_data | output | 128 | Front load response line |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | 32 | Line-aligned memory address |
| mem_req_wdata | output | 128 | Write-back data (zero for reads) |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_resp_valid | input | 1 | Memory read data available |
| mem_resp_data | input | 128 | Memory read line |
| mem_resp_ready | output | 1 | Controller consumes the memory response |
| inv_valid | output | 1 | Invalidate for the first-level cache pending |
| inv_addr | output | 32 | Line-aligned address to invalidate |
| inv_ready | input | 1 | First-level cache takes the invalidate |

## Verification
A request offered at edge N sits in the input queue after N. It is looked up against the array during the next cycle, and that lookup's effects become visible after edge N+1. The effects are a queued hit response, a loaded memory or invalidate slot, or a written line. A memory answer accepted at edge M makes its fill, and for a load the response, visible right after M. The bench drives inputs on the falling edge and advances a behavioural model at the rising edge. It then compares every output of the block against the model on the following falling edge, so each result is checked in the first half-cycle it is due. A bench-side line memory replays write-backs into later fills, so a line evicted dirty and fetched again must come back with its stored value.

// File: rtl/l2c_pkg.sv
package l2c_pkg;

  localparam int DEF_ADDR_W     = 32;
  localparam int DEF_WORD_W     = 32;
  localparam int DEF_LINE_WORDS = 4;
  localparam int DEF_SETS       = 64;
  localparam int DEF_QDEPTH     = 2;

  // outcome of looking up the head request in the array
  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_HIT   = 2'd1,
    LK_DIRTY = 2'd2,
    LK_MISS  = 2'd3
  } lookup_e;

endpackage

// File: rtl/l2c_fifo.sv
module l2c_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         empty,
  output logic         full,
  output logic [W-1:0] head
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     slot_q [DEPTH];
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CNT_W'(DEPTH));
    do_push = push && !full;
    do_pop  = pop && !empty;
    wr_d    = do_push ? bump(wr_q) : wr_q;
    rd_d    = do_pop  ? bump(rd_q) : rd_q;
    cnt_d   = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    head    = slot_q[rd_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // payload storage carries no reset
  always_ff @(posedge clk) begin
    if (do_push) begin
      slot_q[wr_q] <= push_data;
    end
  end

endmodule

// File: rtl/l2c_array.sv
module l2c_array #(
  parameter int SETS   = 64,
  parameter int TAG_W  = 22,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [$clog2(SETS)-1:0] rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [$clog2(SETS)-1:0] wr_idx,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data
);

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_comb begin
    rd_valid = valid_q[rd_idx];
    rd_dirty = dirty_q[rd_idx];
    rd_tag   = tag_q[rd_idx];
    rd_data  = line_q[rd_idx];
  end

  // state bits: reset clears every line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  // tag and data storage: enable only, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      line_q[wr_idx] <= wr_data;
    end
  end

endmodule

// File: rtl/l2c_ctrl.sv
module l2c_ctrl
  import l2c_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 6,
  parameter int LINE_W = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  // head of the input queue
  input  logic                      head_valid,
  input  logic                      head_store,
  input  logic [ADDR_W-OFF_W-1:0]   head_laddr,
  input  logic [LINE_W-1:0]         head_wdata,
  output logic                      head_pop,
  // response queue
  input  logic                      resp_full,
  output logic                      resp_push,
  output logic [LINE_W-1:0]         resp_push_data,
  // array
  output logic [IDX_W-1:0]          arr_rd_idx,
  input  logic                      arr_rd_valid,
  input  logic                      arr_rd_dirty,
  input  logic [ADDR_W-OFF_W-IDX_W-1:0] arr_rd_tag,
  input  logic [LINE_W-1:0]         arr_rd_data,
  output logic                      arr_wr_en,
  output logic [IDX_W-1:0]          arr_wr_idx,
  output logic                      arr_wr_valid,
  output logic                      arr_wr_dirty,
  output logic [ADDR_W-OFF_W-IDX_W-1:0] arr_wr_tag,
  output logic [LINE_W-1:0]         arr_wr_data,
  // memory
  output logic                      mem_req_valid,
  output logic                      mem_req_write,
  output logic [ADDR_W-1:0]         mem_req_addr,
  output logic [LINE_W-1:0]         mem_req_wdata,
  input  logic                      mem_req_ready,
  input  logic                      mem_resp_valid,
  input  logic [LINE_W-1:0]         mem_resp_data,
  output logic                      mem_resp_ready,
  // back-invalidate
  output logic                      inv_valid,
  output logic [ADDR_W-1:0]         inv_addr,
  input  logic                      inv_ready
);

  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int TAG_W   = LADDR_W - IDX_W;

  // outstanding miss record
  logic               miss_v_q, miss_v_d;
  logic               miss_st_q, miss_st_d;
  logic [LADDR_W-1:0] miss_la_q, miss_la_d;
  logic [LINE_W-1:0]  miss_wd_q, miss_wd_d;
  // one-entry memory request slot
  logic               mq_v_q, mq_v_d;
  logic               mq_wr_q, mq_wr_d;
  logic [LADDR_W-1:0] mq_la_q, mq_la_d;
  logic [LINE_W-1:0]  mq_wd_q, mq_wd_d;
  // one-entry invalidate slot
  logic               iv_v_q, iv_v_d;
  logic [LADDR_W-1:0] iv_la_q, iv_la_d;

  logic [IDX_W-1:0]   head_idx;
  logic [TAG_W-1:0]   head_tag;
  logic [LADDR_W-1:0] victim_la;
  logic               lookup_en, fill_ok, take_ok;
  lookup_e            outcome;

  always_comb begin
    head_idx   = head_laddr[IDX_W-1:0];
    head_tag   = head_laddr[LADDR_W-1:IDX_W];
    victim_la  = {arr_rd_tag, head_idx};
    arr_rd_idx = head_idx;

    lookup_en = head_valid && !miss_v_q && !mq_v_q && !iv_v_q;
    if (!lookup_en) begin
      outcome = LK_IDLE;
    end else if (arr_rd_valid && (arr_rd_tag == head_tag)) begin
      outcome = LK_HIT;
    end else if (arr_rd_valid && arr_rd_dirty) begin
      outcome = LK_DIRTY;
    end else begin
      outcome = LK_MISS;
    end

    take_ok = miss_v_q && (miss_st_q || !resp_full);
    fill_ok = take_ok && mem_resp_valid;
  end

  // next-state logic
  always_comb begin
    head_pop       = 1'b0;
    resp_push      = 1'b0;
    resp_push_data = arr_rd_data;
    arr_wr_en      = 1'b0;
    arr_wr_idx     = head_idx;
    arr_wr_valid   = 1'b0;
    arr_wr_dirty   = 1'b0;
    arr_wr_tag     = arr_rd_tag;
    arr_wr_data    = arr_rd_data;

    miss_v_d  = miss_v_q;
    miss_st_d = miss_st_q;
    miss_la_d = miss_la_q;
    miss_wd_d = miss_wd_q;
    mq_v_d    = mq_v_q && !mem_req_ready;
    mq_wr_d   = mq_wr_q;
    mq_la_d   = mq_la_q;
    mq_wd_d   = mq_wd_q;
    iv_v_d    = iv_v_q && !inv_ready;
    iv_la_d   = iv_la_q;

    if (fill_ok) begin
      arr_wr_en    = 1'b1;
      arr_wr_idx   = miss_la_q[IDX_W-1:0];
      arr_wr_tag   = miss_la_q[LADDR_W-1:IDX_W];
      arr_wr_valid = 1'b1;
      arr_wr_dirty = miss_st_q;
      arr_wr_data  = miss_st_q ? miss_wd_q : mem_resp_data;
      resp_push      = !miss_st_q;
      resp_push_data = mem_resp_data;
      miss_v_d       = 1'b0;
    end

    unique case (outcome)
      LK_HIT: begin
        if (head_store) begin
          arr_wr_en    = 1'b1;
          arr_wr_valid = 1'b1;
          arr_wr_dirty = 1'b1;
          arr_wr_tag   = head_tag;
          arr_wr_data  = head_wdata;
          head_pop     = 1'b1;
        end else if (!resp_full) begin
          resp_push      = 1'b1;
          resp_push_data = arr_rd_data;
          head_pop       = 1'b1;
        end
      end
      LK_DIRTY: begin
        // drop the line, write it back, tell the upper level; retry later
        arr_wr_en = 1'b1;
        mq_v_d    = 1'b1;
        mq_wr_d   = 1'b1;
        mq_la_d   = victim_la;
        mq_wd_d   = arr_rd_data;
        iv_v_d    = 1'b1;
        iv_la_d   = victim_la;
      end
      LK_MISS: begin
        if (arr_rd_valid) begin
          arr_wr_en = 1'b1;
          iv_v_d    = 1'b1;
          iv_la_d   = victim_la;
        end
        mq_v_d    = 1'b1;
        mq_wr_d   = 1'b0;
        mq_la_d   = head_laddr;
        mq_wd_d   = '0;
        miss_v_d  = 1'b1;
        miss_st_d = head_store;
        miss_la_d = head_laddr;
        miss_wd_d = head_wdata;
        head_pop  = 1'b1;
      end
      default: ;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_v_q <= 1'b0;
      mq_v_q   <= 1'b0;
      iv_v_q   <= 1'b0;
    end else begin
      miss_v_q <= miss_v_d;
      mq_v_q   <= mq_v_d;
      iv_v_q   <= iv_v_d;
    end
  end

  // payload registers, loaded only when their slot is filled
  always_ff @(posedge clk) begin
    if (outcome == LK_MISS) begin
      miss_st_q <= miss_st_d;
      miss_la_q <= miss_la_d;
      miss_wd_q <= miss_wd_d;
    end
    if (mq_v_d && !mq_v_q) begin
      mq_wr_q <= mq_wr_d;
      mq_la_q <= mq_la_d;
      mq_wd_q <= mq_wd_d;
    end
    if (iv_v_d && !iv_v_q) begin
      iv_la_q <= iv_la_d;
    end
  end

  always_comb begin
    mem_req_valid  = mq_v_q;
    mem_req_write  = mq_wr_q;
    mem_req_addr   = {mq_la_q, {OFF_W{1'b0}}};
    mem_req_wdata  = mq_wd_q;
    mem_resp_ready = take_ok;
    inv_valid      = iv_v_q;
    inv_addr       = {iv_la_q, {OFF_W{1'b0}}};
  end

endmodule

// File: rtl/l2_inclusive_cache.sv
module l2_inclusive_cache
  import l2c_pkg::*;
#(
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int WORD_W     = DEF_WORD_W,
  parameter int LINE_WORDS = DEF_LINE_WORDS,
  parameter int SETS       = DEF_SETS,
  parameter int QDEPTH     = DEF_QDEPTH
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_store,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [WORD_W*LINE_WORDS-1:0] req_wdata,
  output logic                         req_accepted,
  input  logic                         resp_take,
  output logic                         resp_valid,
  output logic [WORD_W*LINE_WORDS-1:0] resp_data,
  output logic                         mem_req_valid,
  output logic                         mem_req_write,
  output logic [ADDR_W-1:0]            mem_req_addr,
  output logic [WORD_W*LINE_WORDS-1:0] mem_req_wdata,
  input  logic                         mem_req_ready,
  input  logic                         mem_resp_valid,
  input  logic [WORD_W*LINE_WORDS-1:0] mem_resp_data,
  output logic                         mem_resp_ready,
  output logic                         inv_valid,
  output logic [ADDR_W-1:0]            inv_addr,
  input  logic                         inv_ready
);

  localparam int LINE_W  = WORD_W * LINE_WORDS;
  localparam int OFF_W   = $clog2(LINE_W / 8);
  localparam int IDX_W   = $clog2(SETS);
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int TAG_W   = LADDR_W - IDX_W;
  localparam int REQ_W   = 1 + LADDR_W + LINE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  // byte offset does not take part in any decision
  logic unused_offset;
  assign unused_offset = ^req_addr[OFF_W-1:0];

  logic               rq_empty, rq_full, rq_pop;
  logic [REQ_W-1:0]   rq_head;
  logic               rs_empty, rs_full, rs_push;
  logic [LINE_W-1:0]  rs_push_data;

  logic [IDX_W-1:0]   rd_idx, wr_idx;
  logic               rd_valid, rd_dirty, wr_en, wr_valid, wr_dirty;
  logic [TAG_W-1:0]   rd_tag, wr_tag;
  logic [LINE_W-1:0]  rd_data, wr_data;

  assign req_accepted = !rq_full;
  assign resp_valid   = !rs_empty;

  l2c_fifo #(.W(REQ_W), .DEPTH(QDEPTH)) u_req_q (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .push      (req_valid),
    .push_data ({req_store, req_addr[ADDR_W-1:OFF_W], req_wdata}),
    .pop       (rq_pop),
    .empty     (rq_empty),
    .full      (rq_full),
    .head      (rq_head)
  );

  l2c_fifo #(.W(LINE_W), .DEPTH(QDEPTH)) u_resp_q (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .push      (rs_push),
    .push_data (rs_push_data),
    .pop       (resp_take),
    .empty     (rs_empty),
    .full      (rs_full),
    .head      (resp_data)
  );

  l2c_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_array (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_tag   (rd_tag),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_valid (wr_valid),
    .wr_dirty (wr_dirty),
    .wr_tag   (wr_tag),
    .wr_data  (wr_data)
  );

  l2c_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (core_rst_n),
    .head_valid     (!rq_empty),
    .head_store     (rq_head[REQ_W-1]),
    .head_laddr     (rq_head[LINE_W +: LADDR_W]),
    .head_wdata     (rq_head[LINE_W-1:0]),
    .head_pop       (rq_pop),
    .resp_full      (rs_full),
    .resp_push      (rs_push),
    .resp_push_data (rs_push_data),
    .arr_rd_idx     (rd_idx),
    .arr_rd_valid   (rd_valid),
    .arr_rd_dirty   (rd_dirty),
    .arr_rd_tag     (rd_tag),
    .arr_rd_data    (rd_data),
    .arr_wr_en      (wr_en),
    .arr_wr_idx     (wr_idx),
    .arr_wr_valid   (wr_valid),
    .arr_wr_dirty   (wr_dirty),
    .arr_wr_tag     (wr_tag),
    .arr_wr_data    (wr_data),
    .mem_req_valid  (mem_req_valid),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata),
    .mem_req_ready  (mem_req_ready),
    .mem_resp_valid (mem_resp_valid),
    .mem_resp_data  (mem_resp_data),
    .mem_resp_ready (mem_resp_ready),
    .inv_valid      (inv_valid),
    .inv_addr       (inv_addr),
    .inv_ready      (inv_ready)
  );

endmodule

// File: rtl/l2_inclusive_cache_chk.sv
module l2_inclusive_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [LINE_W-1:0] mem_req_wdata,
  input logic              mem_resp_valid,
  input logic              mem_resp_ready,
  input logic              inv_valid,
  input logic              inv_ready,
  input logic [ADDR_W-1:0] inv_addr,
  input logic              resp_valid,
  input logic              resp_take,
  input logic [LINE_W-1:0] resp_data
);

  // line reads sent to memory and not yet answered
  logic [1:0] reads_out;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reads_out <= 2'd0;
    end else begin
      reads_out <= reads_out
                 + 2'(mem_req_valid && mem_req_ready && !mem_req_write)
                 - 2'(mem_resp_valid && mem_resp_ready);
    end
  end

  assert_one_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reads_out <= 2'd1);

  assert_memreq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata));

  assert_read_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[OFF_W-1:0] == '0);

  assert_inv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_addr));

  assert_inv_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_addr[OFF_W-1:0] == '0);

  assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_take |=> resp_valid && $stable(resp_data));

endmodule

bind l2_inclusive_cache l2_inclusive_cache_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_write  (mem_req_write),
  .mem_req_addr   (mem_req_addr),
  .mem_req_wdata  (mem_req_wdata),
  .mem_resp_valid (mem_resp_valid),
  .mem_resp_ready (mem_resp_ready),
  .inv_valid      (inv_valid),
  .inv_ready      (inv_ready),
  .inv_addr       (inv_addr),
  .resp_valid     (resp_valid),
  .resp_take      (resp_take),
  .resp_data      (resp_data)
);

// File: tb/l2_inclusive_cache_test.sv
module l2_inclusive_cache_test;

  localparam int CLK_PERIOD = 10;
  localparam int NREQ       = 260;
  localparam int LIMIT      = 100000;
  localparam int MEM_LAT    = 3;

  logic         clk, rst_n;
  logic         req_valid, req_store, req_accepted;
  logic [31:0]  req_addr;
  logic [127:0] req_wdata;
  logic         resp_take, resp_valid;
  logic [127:0] resp_data;
  logic         mem_req_valid, mem_req_write, mem_req_ready;
  logic [31:0]  mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic         mem_resp_valid, mem_resp_ready;
  logic [127:0] mem_resp_data;
  logic         inv_valid, inv_ready;
  logic [31:0]  inv_addr;

  l2_inclusive_cache uut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // stimulus
  logic         st_s [NREQ];
  logic [31:0]  st_a [NREQ];
  logic [127:0] st_d [NREQ];
  int unsigned  rng = 32'h1234_5678;

  function automatic int unsigned nextr(ref int unsigned x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic [31:0] mk_addr(input int tg, input int idx, input int off);
    return {22'(tg), 6'(idx), 4'(off)};
  endfunction

  // reference model state
  bit           m_v [64];
  bit           m_d [64];
  logic [21:0]  m_tag [64];
  logic [127:0] m_line [64];
  logic         rq_s [$];
  logic [31:0]  rq_a [$];
  logic [127:0] rq_d [$];
  logic [127:0] rsq [$];
  bit           m_missv, m_miss_st;
  logic [31:0]  m_miss_a;
  logic [127:0] m_miss_d;
  bit           m_memv, m_memw;
  logic [31:0]  m_mem_a;
  logic [127:0] m_mem_d;
  bit           m_invv;
  logic [31:0]  m_inv_a;
  logic [127:0] bmem [logic [31:0]];
  logic [31:0]  pend_a [$];
  int           pend_t [$];
  int           sidx = 0, cyc = 0, nwb = 0, ninv = 0, nfill = 0, rd_out = 0;
  bit           running = 0, done = 0, saw_full = 0;

  function automatic logic [127:0] mem_rd(input logic [31:0] a);
    if (bmem.exists(a)) return bmem[a];
    return {a ^ 32'hA5A5_0000, a + 32'd3, ~a, a * 32'd7};
  endfunction

  initial begin
    for (int i = 0; i < NREQ; i++) begin
      st_s[i] = (nextr(rng) % 5) < 2;
      st_a[i] = mk_addr(nextr(rng) % 4, (nextr(rng) % 4 == 3) ? 63 : nextr(rng) % 3, nextr(rng) % 16);
      st_d[i] = {nextr(rng), nextr(rng), 32'(i), 32'hC0DE_0000};
    end
    // directed opening: same set, three tags
    st_s[0] = 0; st_a[0] = mk_addr(1, 5, 0);
    st_s[1] = 0; st_a[1] = mk_addr(1, 5, 8);
    st_s[2] = 1; st_a[2] = mk_addr(1, 5, 4);  st_d[2] = {4{32'hD1D1_0001}};
    st_s[3] = 0; st_a[3] = mk_addr(2, 5, 0);
    st_s[4] = 1; st_a[4] = mk_addr(3, 5, 12); st_d[4] = {4{32'hD2D2_0002}};
    st_s[5] = 0; st_a[5] = mk_addr(3, 5, 0);
    st_s[6] = 0; st_a[6] = mk_addr(1, 5, 0);
  end

  // model step at the rising edge, from the inputs driven on the falling edge
  bit rfull, memfire, invfire, rpop, rpush, lk, fill, do_pop, new_resp;
  logic [127:0] nr_data;
  int idx;
  logic [21:0] tg;

  always @(posedge clk) begin
    if (running) begin
      rfull   = (rsq.size() == 2);
      memfire = m_memv && mem_req_ready;
      invfire = m_invv && inv_ready;
      rpop    = (rsq.size() > 0) && resp_take;
      rpush   = req_valid && (rq_a.size() < 2);
      lk      = (rq_a.size() > 0) && !m_missv && !m_memv && !m_invv;
      fill    = m_missv && mem_resp_valid && (m_miss_st || !rfull);
      do_pop  = 0; new_resp = 0;
      if (memfire) begin
        m_memv = 0;
        if (m_memw) begin bmem[m_mem_a] = m_mem_d; nwb++; end
        else begin pend_a.push_back(m_mem_a); pend_t.push_back(cyc + MEM_LAT); end
      end
      if (invfire) begin m_invv = 0; ninv++; end
      if (fill) begin
        idx = int'(m_miss_a[9:4]);
        m_line[idx] = m_miss_st ? m_miss_d : mem_rd(pend_a[0]);
        m_tag[idx] = m_miss_a[31:10]; m_v[idx] = 1; m_d[idx] = m_miss_st;
        if (!m_miss_st) begin new_resp = 1; nr_data = m_line[idx]; end
        m_missv = 0; nfill++;
        void'(pend_a.pop_front()); void'(pend_t.pop_front());
      end
      if (lk) begin
        idx = int'(rq_a[0][9:4]); tg = rq_a[0][31:10];
        if (m_v[idx] && m_tag[idx] == tg) begin
          if (rq_s[0]) begin m_line[idx] = rq_d[0]; m_d[idx] = 1; do_pop = 1; end
          else if (!rfull) begin new_resp = 1; nr_data = m_line[idx]; do_pop = 1; end
        end else if (m_v[idx] && m_d[idx]) begin
          m_memv = 1; m_memw = 1; m_mem_a = {m_tag[idx], 6'(idx), 4'h0}; m_mem_d = m_line[idx];
          m_invv = 1; m_inv_a = m_mem_a; m_v[idx] = 0; m_d[idx] = 0;
        end else begin
          if (m_v[idx]) begin m_invv = 1; m_inv_a = {m_tag[idx], 6'(idx), 4'h0}; end
          m_v[idx] = 0;
          m_memv = 1; m_memw = 0; m_mem_a = {tg, 6'(idx), 4'h0}; m_mem_d = '0;
          m_missv = 1; m_miss_st = rq_s[0]; m_miss_a = rq_a[0]; m_miss_d = rq_d[0];
          do_pop = 1;
        end
      end
      if (rpop) void'(rsq.pop_front());
      if (new_resp) rsq.push_back(nr_data);
      if (do_pop) begin void'(rq_s.pop_front()); void'(rq_a.pop_front()); void'(rq_d.pop_front()); end
      if (rpush) begin rq_s.push_back(req_store); rq_a.push_back(req_addr); rq_d.push_back(req_wdata); sidx++; end
      cyc++;
    end
  end

  // compare, then drive the next inputs, on the falling edge
  always @(negedge clk) begin
    if (running && !done) begin
      chk(req_accepted == (rq_a.size() < 2), "R2 req_accepted", 128'(req_accepted), 128'(rq_a.size() < 2));
      if (rq_a.size() == 2) saw_full = 1;
      chk(resp_valid == (rsq.size() > 0), "R10 resp_valid", 128'(resp_valid), 128'(rsq.size() > 0));
      if (rsq.size() > 0)
        chk(resp_data === rsq[0], "R4 R7 resp_data", resp_data, rsq[0]);
      chk(mem_req_valid == m_memv, "R9 mem_req_valid", 128'(mem_req_valid), 128'(m_memv));
      if (m_memv) begin
        chk(mem_req_write == m_memw && mem_req_addr === m_mem_a, "R5 R6 mem_req kind/addr",
            {mem_req_write, mem_req_addr}, {m_memw, m_mem_a});
        if (m_memw) chk(mem_req_wdata === m_mem_d, "R5 writeback data", mem_req_wdata, m_mem_d);
      end
      chk(inv_valid == m_invv, "R8 inv_valid", 128'(inv_valid), 128'(m_invv));
      if (m_invv) chk(inv_addr === m_inv_a, "R8 inv_addr", 128'(inv_addr), 128'(m_inv_a));
      chk(mem_resp_ready == (m_missv && (m_miss_st || rsq.size() < 2)), "R7 mem_resp_ready",
          128'(mem_resp_ready), 128'(m_missv && (m_miss_st || rsq.size() < 2)));

      // drive
      req_valid = (sidx < NREQ) && (nextr(rng) % 4 != 0);
      if (sidx < NREQ) begin req_store = st_s[sidx]; req_addr = st_a[sidx]; req_wdata = st_d[sidx]; end
      resp_take     = (nextr(rng) % 3 != 0);
      mem_req_ready = nextr(rng)[4];
      inv_ready     = (cyc >= 100 && cyc < 160) ? 1'b0 : nextr(rng)[7];
      mem_resp_valid = (pend_a.size() > 0) && (cyc >= pend_t[0]);
      mem_resp_data  = (pend_a.size() > 0) ? mem_rd(pend_a[0]) : '0;

      // read handshakes that will complete at the next rising edge
      if (mem_req_valid && mem_req_ready && !mem_req_write) rd_out++;
      if (mem_resp_valid && mem_resp_ready) rd_out--;
      chk(rd_out <= 1, "R3 reads in flight", 128'(rd_out), 128'(1));

      if (sidx == NREQ && rq_a.size() == 0 && rsq.size() == 0 && !m_missv && !m_memv &&
          !m_invv && pend_a.size() == 0)
        done = 1;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_store = 0; req_addr = '0; req_wdata = '0;
    resp_take = 0; mem_req_ready = 0; mem_resp_valid = 0; mem_resp_data = '0; inv_ready = 0;
    m_missv = 0; m_memv = 0; m_invv = 0;
    for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_d[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle outputs after reset
    chk(req_accepted === 1'b1, "R1 req_accepted", 128'(req_accepted), 128'(1));
    chk(resp_valid === 1'b0, "R1 resp_valid", 128'(resp_valid), 128'(0));
    chk(mem_req_valid === 1'b0, "R1 mem_req_valid", 128'(mem_req_valid), 128'(0));
    chk(inv_valid === 1'b0, "R1 inv_valid", 128'(inv_valid), 128'(0));
    chk(mem_resp_ready === 1'b0, "R1 mem_resp_ready", 128'(mem_resp_ready), 128'(0));
    running = 1;
    while (!done && cyc < LIMIT) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not drain actual=%0d expected<%0d", cyc, LIMIT);
    end
    // coverage of the behaviours the run had to reach
    chk(saw_full, "R2 queue reached two entries", 128'(saw_full), 128'(1));
    chk(nwb > 0, "R5 dirty writebacks seen", 128'(nwb), 128'(1));
    chk(ninv > 0, "R8 invalidates taken", 128'(ninv), 128'(1));
    chk(nfill > 0, "R6 R7 fills seen", 128'(nfill), 128'(1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule